// File: doc/BRIEF.md
# Read-Only Port Write Adapter

This block lets a host write external memory through a bus port that only ever issues reads. The port has two banks, each with its own active-low select. A read to the upper bank carries a 16-bit payload in its address lines. The block keeps that payload in a holding register. A later read to the lower bank makes the block drive the held word onto the data bus. At the same time it pulls an active-low write strobe, and the external memory stores the word at the lower-bank address of that read.

The lowest address bit never reaches the port, so the block rebuilds it from the two byte strobes. A byte read at an odd upper-bank address therefore still carries all 16 payload bits. For example, storing 0xCD01 at word address 0x3BC0 takes a byte read of upper-bank offset 0xCD01 followed by a word read of lower-bank offset 0x3BC0. The host reads back the word it wrote, and it can compare that value as a self-test. All port inputs are sampled with a system clock through a short register chain before any decision is made.

Top module: `rdport_write_adapter`

## Requirements
- R1: After reset the holding register is 0x0000, `dout` is 0x0000, and `drv_en_n` and `wr_n` are both high.
- R2: An upper-bank read in which both byte strobes are active captures the payload {A15..A1, 0}, with address line A15 at payload bit 15.
- R3: During an upper-bank read the rebuilt bit 0 is 1 only when the lower byte strobe alone is active. With the upper byte strobe alone it is 0.
- R4: The holding register takes the new payload on the clock edge where the sampled upper-bank select goes from active to inactive. A lower-bank read that starts in that same cycle already writes the new word.
- R5: While a lower-bank read is in progress, `drv_en_n` and `wr_n` are low and `dout` equals the held word.
- R6: `drv_en_n` and `wr_n` return high one clock after the sampled lower-bank select goes inactive.
- R7: Back-to-back upper-bank reads each overwrite the payload, and only the most recent one is written by the next lower-bank read.
- R8: `wr_n` never goes low because of an upper-bank read.
- R9: If both bank selects are active at once, `wr_n` and `drv_en_n` stay high. An upper-bank cycle that saw both selects active does not change the holding register.
- R10: A lower-bank read leaves the holding register unchanged, so a second lower-bank read writes the same word again.
- R11: Inputs pass through SYNC_STAGES sampling registers (default 1), then through the output register. With the default, an input change shows at the outputs at the second rising edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| upper_stb_n | input | 1 | Upper byte strobe, active low |
| lower_stb_n | input | 1 | Lower byte strobe, active low |
| bank_lo_sel_n | input | 1 | Lower-bank (write target) select, active low |
| bank_hi_sel_n | input | 1 | Upper-bank (payload) select, active low |
| addr_i | input | ADDR_W (15) | Address lines A15..A1, A15 in the top bit |
| drv_en_n | output | 1 | Data-bus drive enable, active low |
| dout | output | ADDR_W+1 (16) | Word presented on the data bus |
| wr_n | output | 1 | Write strobe to external memory, active low |

## Verification
The hardest case to reach is the edge where the upper-bank cycle ends and a lower-bank cycle begins in the same clock. Here the write must already carry the word that is loaded on that very edge. The bench releases the upper select and asserts the lower select in the same drive step, with no idle cycle between them. A second hard case is an upper-bank cycle poisoned by an overlapping lower select. The bench drives such a cycle and checks that neither a strobe nor a capture leaks out of it. It then confirms, with a clean lower-bank read, that the old word is still in the holding register.

// File: rtl/rdport_write_adapter_pkg.sv
`timescale 1ns/1ps
package rdport_write_adapter_pkg;

  // Port control lines after polarity conversion (1 = active)
  typedef struct packed {
    logic ub;   // upper byte strobe
    logic lb;   // lower byte strobe
    logic lo;   // lower (target) bank select
    logic hi;   // upper (payload) bank select
  } port_ctl_t;

  function automatic port_ctl_t to_active_high(input logic ub_n, input logic lb_n,
                                               input logic lo_n, input logic hi_n);
    port_ctl_t c;
    c.ub = ~ub_n;
    c.lb = ~lb_n;
    c.lo = ~lo_n;
    c.hi = ~hi_n;
    return c;
  endfunction

endpackage

// File: rtl/rdport_sampler.sv
`timescale 1ns/1ps
module rdport_sampler
  import rdport_write_adapter_pkg::*;
#(
  parameter int STAGES = 1,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  port_ctl_t         ctl_in,
  output logic [ADDR_W-1:0] addr_out,
  output port_ctl_t         ctl_out
);

  logic [ADDR_W-1:0] a_pipe [STAGES];
  port_ctl_t         c_pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          a_pipe[g] <= '0;
          c_pipe[g] <= '0;
        end else begin
          a_pipe[g] <= addr_in;
          c_pipe[g] <= ctl_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          a_pipe[g] <= '0;
          c_pipe[g] <= '0;
        end else begin
          a_pipe[g] <= a_pipe[g-1];
          c_pipe[g] <= c_pipe[g-1];
        end
      end
    end
  end

  assign addr_out = a_pipe[STAGES-1];
  assign ctl_out  = c_pipe[STAGES-1];

endmodule

// File: rtl/rdport_capture.sv
`timescale 1ns/1ps
module rdport_capture
  import rdport_write_adapter_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ADDR_W-1:0] addr_s,
  input  port_ctl_t       ctl_s,
  output logic [ADDR_W:0] hold_q,
  output logic [ADDR_W:0] hold_d
);

  localparam int WORD_W = ADDR_W + 1;

  logic              hi_prev_q;
  logic              poison_q;
  logic              pend_ok_q;
  logic [WORD_W-1:0] pend_q;

  logic hi_only, both_sel, any_stb, rebuilt_a0, hi_rise, hi_fall, take, load;

  always_comb begin
    hi_only    = ctl_s.hi & ~ctl_s.lo;
    both_sel   = ctl_s.hi &  ctl_s.lo;
    any_stb    = ctl_s.ub | ctl_s.lb;
    rebuilt_a0 = ctl_s.lb & ~ctl_s.ub;
    hi_rise    = ctl_s.hi & ~hi_prev_q;
    hi_fall    = ~ctl_s.hi & hi_prev_q;
    take       = hi_only & any_stb & ~poison_q;
    load       = hi_fall & pend_ok_q & ~poison_q;
    hold_d     = load ? pend_q : hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_prev_q <= 1'b0;
      poison_q  <= 1'b0;
      pend_ok_q <= 1'b0;
      pend_q    <= '0;
      hold_q    <= '0;
    end else begin
      hi_prev_q <= ctl_s.hi;
      hold_q    <= hold_d;

      if (hi_fall)       poison_q <= 1'b0;
      else if (both_sel) poison_q <= 1'b1;

      if (both_sel)                pend_ok_q <= 1'b0;
      else if (take)               pend_ok_q <= 1'b1;
      else if (hi_rise || hi_fall) pend_ok_q <= 1'b0;

      if (take) pend_q <= {addr_s, rebuilt_a0};
    end
  end

endmodule

// File: rtl/rdport_strobe_ctl.sv
`timescale 1ns/1ps
module rdport_strobe_ctl
  import rdport_write_adapter_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  port_ctl_t         ctl_s,
  input  logic [WORD_W-1:0] word_next,
  output logic              drv_en_n,
  output logic              wr_n,
  output logic [WORD_W-1:0] dout
);

  logic write_cycle;

  always_comb write_cycle = ctl_s.lo & ~ctl_s.hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en_n <= 1'b1;
      wr_n     <= 1'b1;
      dout     <= '0;
    end else begin
      drv_en_n <= ~write_cycle;
      wr_n     <= ~write_cycle;
      dout     <= word_next;
    end
  end

endmodule

// File: rtl/rdport_write_adapter.sv
`timescale 1ns/1ps
module rdport_write_adapter
  import rdport_write_adapter_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upper_stb_n,
  input  logic              lower_stb_n,
  input  logic              bank_lo_sel_n,
  input  logic              bank_hi_sel_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              drv_en_n,
  output logic [ADDR_W:0]   dout,
  output logic              wr_n
);

  localparam int WORD_W = ADDR_W + 1;

  port_ctl_t         ctl_raw;
  port_ctl_t         ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] hold_d;

  always_comb ctl_raw = to_active_high(upper_stb_n, lower_stb_n, bank_lo_sel_n, bank_hi_sel_n);

  rdport_sampler #(.STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)) u_sample (
    .clk(clk), .rst(rst), .addr_in(addr_i), .ctl_in(ctl_raw),
    .addr_out(addr_s), .ctl_out(ctl_s)
  );

  rdport_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .rst(rst), .addr_s(addr_s), .ctl_s(ctl_s),
    .hold_q(hold_q), .hold_d(hold_d)
  );

  rdport_strobe_ctl #(.WORD_W(WORD_W)) u_strobe (
    .clk(clk), .rst(rst), .ctl_s(ctl_s), .word_next(hold_d),
    .drv_en_n(drv_en_n), .wr_n(wr_n), .dout(dout)
  );

endmodule

// File: rtl/rdport_write_adapter_chk.sv
`timescale 1ns/1ps
module rdport_write_adapter_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              lo_s,
  input logic              hi_s,
  input logic              drv_en_n,
  input logic              wr_n,
  input logic [WORD_W-1:0] dout,
  input logic [WORD_W-1:0] hold_q
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (wr_n && drv_en_n && hold_q == '0)); // R1

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(hi_s, 2)) |-> $stable(hold_q)); // R4

  AST_STROBE_SRC: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> $past(lo_s && !hi_s)); // R5

  AST_DRIVE_DATA: assert property (@(posedge clk) disable iff (rst)
    !drv_en_n |-> (dout == hold_q)); // R5

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $past(!lo_s) |-> (wr_n && drv_en_n)); // R6

  AST_NO_HI_STROBE: assert property (@(posedge clk) disable iff (rst)
    $past(hi_s) |-> (wr_n && drv_en_n)); // R8

endmodule

bind rdport_write_adapter rdport_write_adapter_chk #(.WORD_W(ADDR_W + 1)) chk_i (
  .clk(clk), .rst(rst), .lo_s(ctl_s.lo), .hi_s(ctl_s.hi),
  .drv_en_n(drv_en_n), .wr_n(wr_n), .dout(dout), .hold_q(hold_q)
);

// File: tb/rdport_write_adapter_tb_top.sv
`timescale 1ns/1ps
module rdport_write_adapter_tb_top;

  localparam int ADDR_W = 15;
  localparam real CLK_NS = 4.0;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              upper_stb_n = 1'b1;
  logic              lower_stb_n = 1'b1;
  logic              bank_lo_sel_n = 1'b1;
  logic              bank_hi_sel_n = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              drv_en_n;
  logic [ADDR_W:0]   dout;
  logic              wr_n;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_NS / 2.0) clk = ~clk;

  rdport_write_adapter #(.ADDR_W(ADDR_W), .SYNC_STAGES(1)) dut_i (
    .clk(clk), .rst(rst), .upper_stb_n(upper_stb_n), .lower_stb_n(lower_stb_n),
    .bank_lo_sel_n(bank_lo_sel_n), .bank_hi_sel_n(bank_hi_sel_n), .addr_i(addr_i),
    .drv_en_n(drv_en_n), .dout(dout), .wr_n(wr_n)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    bank_hi_sel_n = 1'b1;
    bank_lo_sel_n = 1'b1;
    upper_stb_n   = 1'b1;
    lower_stb_n   = 1'b1;
  endtask

  // Upper-bank read carrying a payload; strobes never allowed during it (R8)
  task automatic upper_read(input logic [ADDR_W-1:0] a, input logic ub, input logic lb,
                            input bit leave_open);
    addr_i        = a;
    upper_stb_n   = ~ub;
    lower_stb_n   = ~lb;
    bank_hi_sel_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(1);
      check("R8 wr_n during upper read", {31'd0, wr_n}, 32'd1);
    end
    if (!leave_open) begin
      bus_idle();
      step(1);
    end
  endtask

  // Lower-bank write: latency (R11), active phase (R5), release (R6)
  task automatic lower_read(input logic [ADDR_W-1:0] a, input logic [15:0] exp, input string tag);
    addr_i        = a;
    bank_hi_sel_n = 1'b1;
    upper_stb_n   = 1'b0;
    lower_stb_n   = 1'b0;
    bank_lo_sel_n = 1'b0;
    step(1);
    check("R11 strobe not yet after one edge", {31'd0, wr_n}, 32'd1);
    step(1);
    check({"R5 drv_en_n ", tag}, {31'd0, drv_en_n}, 32'd0);
    check({"R5 wr_n ", tag}, {31'd0, wr_n}, 32'd0);
    check({"R5 dout ", tag}, {16'd0, dout}, {16'd0, exp});
    step(2);
    check({"R5 dout held ", tag}, {16'd0, dout}, {16'd0, exp});
    bus_idle();
    step(1);
    check("R6 wr_n still low before release edge", {31'd0, wr_n}, 32'd0);
    step(1);
    check("R6 wr_n released", {31'd0, wr_n}, 32'd1);
    check("R6 drv_en_n released", {31'd0, drv_en_n}, 32'd1);
  endtask

  task automatic t_reset();
    check("R1 wr_n", {31'd0, wr_n}, 32'd1);
    check("R1 drv_en_n", {31'd0, drv_en_n}, 32'd1);
    check("R1 dout", {16'd0, dout}, 32'd0);
    lower_read(15'h0001, 16'h0000, "R1 held word after reset");
  endtask

  task automatic t_word();
    upper_read(15'h52D2, 1'b1, 1'b1, 1'b0);   // payload 0xA5A4
    lower_read(15'h0100, 16'hA5A4, "R2 word payload");
  endtask

  task automatic t_byte();
    upper_read(15'h6680, 1'b0, 1'b1, 1'b0);   // odd byte -> 0xCD01
    lower_read(15'h3BC0, 16'hCD01, "R3 lower strobe only");
    upper_read(15'h6680, 1'b1, 1'b0, 1'b0);   // even byte -> 0xCD00
    lower_read(15'h3BC0, 16'hCD00, "R3 upper strobe only");
  endtask

  task automatic t_back_to_back();
    upper_read(15'h0787, 1'b1, 1'b1, 1'b1);   // payload 0x0F0E, select left open
    lower_read(15'h0042, 16'h0F0E, "R4 same-cycle handoff");
  endtask

  task automatic t_repeat();
    upper_read(15'h0888, 1'b1, 1'b1, 1'b0);
    upper_read(15'h1111, 1'b1, 1'b1, 1'b0);
    upper_read(15'h199A, 1'b1, 1'b1, 1'b0);   // last: 0x3334
    lower_read(15'h0200, 16'h3334, "R7 last upper read wins");
  endtask

  task automatic t_illegal();
    upper_read(15'h2AAB, 1'b1, 1'b1, 1'b0);   // payload 0x5556
    addr_i        = 15'h3BBC;
    upper_stb_n   = 1'b0;
    lower_stb_n   = 1'b0;
    bank_hi_sel_n = 1'b0;
    bank_lo_sel_n = 1'b0;
    step(2);
    check("R9 wr_n with both selects", {31'd0, wr_n}, 32'd1);
    check("R9 drv_en_n with both selects", {31'd0, drv_en_n}, 32'd1);
    bank_lo_sel_n = 1'b1;                      // upper cycle continues, already poisoned
    step(2);
    check("R9 wr_n after overlap", {31'd0, wr_n}, 32'd1);
    bus_idle();
    step(2);
    lower_read(15'h0300, 16'h5556, "R9 poisoned cycle not captured");
  endtask

  task automatic t_rewrite();
    lower_read(15'h0301, 16'h5556, "R10 second lower read same word");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_word();
    t_byte();
    t_back_to_back();
    t_repeat();
    t_illegal();
    t_rewrite();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule